// File: doc/BRIEF.md
# Twelve-Pin General-Purpose I/O Port with Output Disable

This block is a 12-pin bidirectional port reached through a small register bus. Each pin is either plain general I/O, steered by a direction bit and a data bit, or it hands itself to an alternate function. Pins 0 to 3 can drive timer compare outputs. Pins 4 and 5 can feed timer clock inputs. Pins 6 to 11 can drive the upper address lines 16 to 21. The pad is seen as a separate output value and output enable per pin. The block drives no real tristate net.

An active-low output-disable input can silence every pin that is acting as a general output. It has no effect on pins that carry an alternate output. A mode input selects single-chip operation. In that mode the address alternates do not exist, so pins 6 to 11 stay general I/O whatever their function bits hold. Pin levels and the disable input each pass through a two-flop synchronizer before any logic uses them.

A bus read of the port register is assembled per pin. A pin that drives returns its data bit. A pin that listens returns its synchronized level. A write always lands in the data register. Read data is registered and appears one cycle after the request.

Top module: `gpioPort`

## Requirements
- R1: After reset the data, direction and function registers are all zero, every output enable is low, and the read-data output is zero.
- R2: A write to offset 0 always stores the write data in the data register, whatever the pins' modes, and a pin that later becomes a general output drives the stored bit.
- R3: A read of offset 0 returns, for a general-input pin, the pin level seen through two synchronizer flops. A pin change therefore reaches the read data only for a read captured at least two clock edges after the change.
- R4: A read of offset 0 returns the data register bit for a pin that is a general output or an alternate output, not the pin level.
- R5: A general-output pin (function bit 0, direction bit 1) has its output enable high only while the synchronized output-disable input is high. Its output value is its data bit. A change of the disable input reaches the enables on the second clock edge.
- R6: A write to offset 0 leaves the output enable of a general-input pin low.
- R7: When its function bit is 1, each of pins 0 to 3 drives its timer-output input with the enable high, regardless of its direction bit and of the disable input.
- R8: When their function bits are 1, pins 4 and 5 keep their enables low and read back their pin level. The timer clock output always carries the synchronized levels of pins 4 and 5.
- R9: When its function bit is 1 and single-chip mode is low, each of pins 6 to 11 drives address bit (pin minus 6) with the enable high. In single-chip mode these pins behave as general I/O whatever their function bits hold.
- R10: Offset 1 reads back the direction register (1 = output), offset 2 reads back the function register (1 = alternate), and offset 3 reads zero.
- R11: The read-data output is loaded only by a read request. It updates on the clock edge that samples the request and holds through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| singleChip | input | 1 | High removes the address alternates on pins 6 to 11 |
| outDisN | input | 1 | Active-low disable for general-output pins, asynchronous |
| busValid | input | 1 | Bus access request for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register offset: 0 port, 1 direction, 2 function |
| busWdata | input | 12 | Write data |
| busRdata | output | 12 | Registered read data |
| pinIn | input | 12 | Pad input levels, asynchronous |
| pinOut | output | 12 | Pad output values |
| pinOe | output | 12 | Pad output enables, 1 = drive |
| timerOut | input | 4 | Timer compare outputs for pins 0 to 3 |
| timerClk | output | 2 | Synchronized levels of pins 4 and 5 |
| addrHigh | input | 6 | Address lines 16 to 21 for pins 6 to 11 |

## Verification
The interesting coincidence is a data-register write that lands in the same cycle as the output-disable input falling on a port whose pins are all general outputs. The bench drives both in one cycle. It then expects the new data on the pin values with the enables still high after that edge, and all enables low one edge later. A read-back of the port then has to show the new data. A second overlap is a pin change arriving together with a read request. The bench judges that the read returns the old level, and that a read three cycles later returns the new one.

// File: rtl/gpioPortPkg.sv
package gpioPortPkg;

  typedef enum logic [1:0] {
    SEL_PORT = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_FUNC = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrFunc;
    logic    rdEn;
    regSel_e rdSel;
  } portStrobe_t;

endpackage

// File: rtl/portSync.sv
module portSync #(
  parameter int   WIDTH     = 1,
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[0] <= {WIDTH{RESET_VAL}};
        else       stage[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[s] <= {WIDTH{RESET_VAL}};
        else       stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/portCtrl.sv
module portCtrl
  import gpioPortPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [1:0]  busAddr,
  output portStrobe_t stb
);
  regSel_e sel;

  always_comb begin
    unique case (busAddr)
      2'd0:    sel = SEL_PORT;
      2'd1:    sel = SEL_DIR;
      2'd2:    sel = SEL_FUNC;
      default: sel = SEL_NONE;
    endcase
  end

  always_comb begin
    stb        = '0;
    stb.rdSel  = sel;
    stb.rdEn   = busValid && !busWrite;
    stb.wrData = busValid && busWrite && (sel == SEL_PORT);
    stb.wrDir  = busValid && busWrite && (sel == SEL_DIR);
    stb.wrFunc = busValid && busWrite && (sel == SEL_FUNC);
  end

  // R10: at most one register is addressed per access
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrData, stb.wrDir, stb.wrFunc, stb.rdEn}));

endmodule

// File: rtl/portData.sv
module portData
  import gpioPortPkg::*;
#(
  parameter int PINS     = 12,
  parameter int TMR_OUTS = 4,
  parameter int TMR_CLKS = 2,
  parameter int ADR_PINS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  portStrobe_t         stb,
  input  logic [PINS-1:0]     wdata,
  output logic [PINS-1:0]     rdata,
  input  logic                singleChip,
  input  logic                odSync,
  input  logic [PINS-1:0]     pinSync,
  output logic [PINS-1:0]     pinOut,
  output logic [PINS-1:0]     pinOe,
  input  logic [TMR_OUTS-1:0] timerOut,
  output logic [TMR_CLKS-1:0] timerClk,
  input  logic [ADR_PINS-1:0] addrHigh
);
  localparam int CLK_LO = TMR_OUTS;
  localparam int ADR_LO = PINS - ADR_PINS;

  logic [PINS-1:0] dataReg, dirReg, funcReg;
  logic [PINS-1:0] altAvail, altIsOut, altSrc;
  logic [PINS-1:0] drivesAlt, genOut, portView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
      funcReg <= '0;
    end else begin
      if (stb.wrData) dataReg <= wdata;
      if (stb.wrDir)  dirReg  <= wdata;
      if (stb.wrFunc) funcReg <= wdata;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    if (i < CLK_LO) begin : g_tmrOut
      assign altAvail[i] = 1'b1;
      assign altIsOut[i] = 1'b1;
      assign altSrc[i]   = timerOut[i];
    end else if (i < CLK_LO + TMR_CLKS) begin : g_tmrClk
      assign altAvail[i] = 1'b1;
      assign altIsOut[i] = 1'b0;
      assign altSrc[i]   = 1'b0;
    end else if (i >= ADR_LO) begin : g_addr
      assign altAvail[i] = !singleChip;
      assign altIsOut[i] = 1'b1;
      assign altSrc[i]   = addrHigh[i-ADR_LO];
    end else begin : g_plain
      assign altAvail[i] = 1'b0;
      assign altIsOut[i] = 1'b0;
      assign altSrc[i]   = 1'b0;
    end

    logic useAlt;
    assign useAlt       = funcReg[i] && altAvail[i];
    assign drivesAlt[i] = useAlt && altIsOut[i];
    assign genOut[i]    = !useAlt && dirReg[i];
    assign pinOe[i]     = drivesAlt[i] || (genOut[i] && odSync);
    assign pinOut[i]    = drivesAlt[i] ? altSrc[i] : dataReg[i];
    assign portView[i]  = (drivesAlt[i] || genOut[i]) ? dataReg[i] : pinSync[i];
  end

  assign timerClk = pinSync[CLK_LO +: TMR_CLKS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (stb.rdEn) begin
      unique case (stb.rdSel)
        SEL_PORT: rdata <= portView;
        SEL_DIR:  rdata <= dirReg;
        SEL_FUNC: rdata <= funcReg;
        default:  rdata <= '0;
      endcase
    end
  end

  // R2: a port write always lands in the data register
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrData |=> (dataReg == $past(wdata)));

  // R11: read data moves only on a read request
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> $stable(rdata));

  // R9: in single-chip mode the address pins drive only as general outputs
  a_r9_single_chip: assert property (@(posedge clk) disable iff (!rstN)
    singleChip |-> ((pinOe[PINS-1:ADR_LO] & ~dirReg[PINS-1:ADR_LO]) == '0));

endmodule

// File: rtl/gpioPort.sv
module gpioPort
  import gpioPortPkg::*;
#(
  parameter int PINS     = 12,
  parameter int TMR_OUTS = 4,
  parameter int TMR_CLKS = 2,
  parameter int ADR_PINS = 6,
  parameter int SYNC_LEN = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                singleChip,
  input  logic                outDisN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [1:0]          busAddr,
  input  logic [PINS-1:0]     busWdata,
  output logic [PINS-1:0]     busRdata,
  input  logic [PINS-1:0]     pinIn,
  output logic [PINS-1:0]     pinOut,
  output logic [PINS-1:0]     pinOe,
  input  logic [TMR_OUTS-1:0] timerOut,
  output logic [TMR_CLKS-1:0] timerClk,
  input  logic [ADR_PINS-1:0] addrHigh
);
  localparam int QUIET_LO = TMR_OUTS;
  localparam int QUIET_HI = PINS - ADR_PINS - 1;

  portStrobe_t     stb;
  logic [PINS-1:0] pinSync;
  logic            odSync;

  portCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .stb(stb)
  );

  portSync #(.WIDTH(PINS), .STAGES(SYNC_LEN), .RESET_VAL(1'b0)) u_pinSync (
    .clk(clk), .rstN(rstN), .d(pinIn), .q(pinSync)
  );

  portSync #(.WIDTH(1), .STAGES(SYNC_LEN), .RESET_VAL(1'b0)) u_odSync (
    .clk(clk), .rstN(rstN), .d(outDisN), .q(odSync)
  );

  portData #(
    .PINS(PINS), .TMR_OUTS(TMR_OUTS), .TMR_CLKS(TMR_CLKS), .ADR_PINS(ADR_PINS)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .rdata(busRdata),
    .singleChip(singleChip), .odSync(odSync), .pinSync(pinSync),
    .pinOut(pinOut), .pinOe(pinOe), .timerOut(timerOut),
    .timerClk(timerClk), .addrHigh(addrHigh)
  );

  // R5: pins with no alternate output go quiet once the disable has been low two cycles
  a_r5_od_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!outDisN ##1 !outDisN) |=> (pinOe[QUIET_HI:QUIET_LO] == '0));

  // R1: no pin drives while reset is applied
  always_comb begin
    if (!rstN) a_r1_reset_quiet: assert (pinOe == '0);
  end

endmodule

// File: tb/sim_gpioPort.sv
module sim_gpioPort;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        singleChip = 1'b0;
  logic        outDisN = 1'b1;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [11:0] busWdata = '0;
  logic [11:0] busRdata;
  logic [11:0] pinIn = 12'hA5C;
  logic [11:0] pinOut, pinOe;
  logic [3:0]  timerOut = 4'hA;
  logic [1:0]  timerClk;
  logic [5:0]  addrHigh = 6'b110011;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpioPort u0 (.*);

  // entry: {req, kind, addr, value}; kind 0 write, 1 read, 2 pinOe, 3 pinOut
  localparam int NVEC = 18;
  localparam logic [19:0] VEC [NVEC] = '{
    {4'd10, 2'd1, 2'd1, 12'h000},  // R10 direction reads zero
    {4'd2,  2'd0, 2'd0, 12'h3C3},  // R2 data write
    {4'd3,  2'd1, 2'd0, 12'hA5C},  // R3 all inputs read pins
    {4'd4,  2'd0, 2'd1, 12'h0FF},
    {4'd4,  2'd1, 2'd0, 12'hAC3},  // R4 mixed view
    {4'd5,  2'd2, 2'd0, 12'h0FF},  // R5 enables
    {4'd5,  2'd3, 2'd0, 12'h3C3},
    {4'd7,  2'd0, 2'd2, 12'h03F},
    {4'd7,  2'd2, 2'd0, 12'h0CF},  // R7 timer outs drive
    {4'd7,  2'd3, 2'd0, 12'h3CA},
    {4'd8,  2'd1, 2'd0, 12'hAD3},  // R8 clock pins read level
    {4'd9,  2'd0, 2'd2, 12'hFC0},
    {4'd9,  2'd0, 2'd1, 12'h000},
    {4'd9,  2'd2, 2'd0, 12'hFC0},  // R9 address pins drive
    {4'd9,  2'd3, 2'd0, 12'hCC3},
    {4'd4,  2'd1, 2'd0, 12'h3DC},
    {4'd10, 2'd1, 2'd2, 12'hFC0},  // R10 function readback
    {4'd10, 2'd1, 2'd3, 12'h000}   // R10 offset 3 zero
  };

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] a, output logic [11:0] v);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    v = busRdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [11:0] v;
    string tag;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oe in reset", pinOe, 12'h000);
    rstN = 1'b1;
    idle(3);
    check("R1 oe", pinOe, 12'h000);
    check("R1 rdata", busRdata, 12'h000);
    check("R1 out", pinOut, 12'h000);
    doRead(2'd2, v); check("R1 func", v, 12'h000);

    for (int n = 0; n < NVEC; n++) begin
      tag = $sformatf("R%0d vec%0d", VEC[n][19:16], n);
      case (VEC[n][15:14])
        2'd0: doWrite(VEC[n][13:12], VEC[n][11:0]);
        2'd1: begin doRead(VEC[n][13:12], v); check(tag, v, VEC[n][11:0]); end
        2'd2: check(tag, pinOe, VEC[n][11:0]);
        default: check(tag, pinOut, VEC[n][11:0]);
      endcase
    end

    // R9 single-chip removes address alternates
    @(negedge clk); singleChip = 1'b1;
    @(negedge clk);
    check("R9 sc oe", pinOe, 12'h000);
    check("R9 sc out", pinOut, 12'h3C3);
    doRead(2'd0, v); check("R9 sc read", v, 12'hA5C);
    singleChip = 1'b0;

    // R6 data write leaves input pins undriven
    doWrite(2'd2, 12'h000);
    doWrite(2'd0, 12'hFFF);
    check("R6 oe", pinOe, 12'h000);
    doRead(2'd0, v); check("R6 read pin", v, 12'hA5C);

    // R5 disable falls in the same cycle as a data write
    doWrite(2'd1, 12'hFFF);
    check("R5 oe on", pinOe, 12'hFFF);
    @(negedge clk);
    outDisN = 1'b0; busValid = 1'b1; busWrite = 1'b1; busAddr = 2'd0; busWdata = 12'h0F0;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    check("R5 oe after 1 edge", pinOe, 12'hFFF);
    check("R2 out new data", pinOut, 12'h0F0);
    @(negedge clk);
    check("R5 oe after 2 edges", pinOe, 12'h000);
    doRead(2'd0, v); check("R4 read while disabled", v, 12'h0F0);
    outDisN = 1'b1;
    @(negedge clk);
    check("R5 release 1 edge", pinOe, 12'h000);
    @(negedge clk);
    check("R5 release 2 edges", pinOe, 12'hFFF);

    // R7 timer outputs ignore the disable
    outDisN = 1'b0;
    doWrite(2'd1, 12'h000);
    doWrite(2'd2, 12'h00F);
    idle(2);
    check("R7 oe", pinOe, 12'h00F);
    check("R7 out", pinOut & 12'h00F, 12'h00A);
    outDisN = 1'b1;

    // R8 timer clock follows synchronized pins 4 and 5
    check("R8 tclk", {10'd0, timerClk}, 12'h001);
    @(negedge clk); pinIn = 12'h123;
    @(negedge clk);
    check("R8 tclk 1 edge", {10'd0, timerClk}, 12'h001);
    @(negedge clk);
    check("R8 tclk 2 edges", {10'd0, timerClk}, 12'h002);

    // R3 synchronizer latency on reads
    doWrite(2'd2, 12'h000);
    @(negedge clk);
    pinIn = 12'h456; busValid = 1'b1; busWrite = 1'b0; busAddr = 2'd0;
    @(negedge clk);
    busValid = 1'b0;
    check("R3 old level", busRdata, 12'h123);
    idle(3);
    doRead(2'd0, v); check("R3 new level", v, 12'h456);

    // R11 read data holds through writes and idle
    doWrite(2'd1, 12'h000);
    check("R11 hold write", busRdata, 12'h456);
    idle(2);
    check("R11 hold idle", busRdata, 12'h456);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule